// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction

This block turns one 4x4 tile of dequantized residual coefficients back into pixels. It takes sixteen signed coefficients and the sixteen 8-bit prediction pixels of the same tile. It runs a separable integer inverse transform: a 1-D pass down every column, then a 1-D pass along every row of the intermediate result. Each final value is rounded, added to its prediction pixel and clamped to the 8-bit pixel range. A mode bit selects a shortcut for tiles that carry only a DC term. In that mode one rounded value, taken from coefficient 0, is added to all sixteen prediction pixels.

Both edges use a valid/ready handshake. Inside there are two register stages: the column pass sits before the first register, and the row pass and reconstruction sit before the second. One tile can be accepted on every cycle, and each result appears two cycles after its input was taken. When the output is stalled, the pipeline fills and then pushes back on the input.

Top module: `itx4_recon`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A tile is taken on a cycle with `in_valid` and `in_ready` both high. With `out_ready` held high, its result is on `out_pix` with `out_valid` high two clock edges later. Results leave in the order the tiles were taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` does not change.
- R4: The two fixed-point product terms are p(x) = sat(x + floor(x*20091 / 65536)) and q(x) = floor(x*35468 / 65536). Here x is a signed coefficient and sat saturates to signed 16 bits.
- R5: Coefficients and pixels are in raster order: element 4*r+k is row r, column k, and bit slice [16*e +: 16] or [8*e +: 8] holds element e. A 1-D pass on the four values v0..v3 of one line computes s = v0+v2, t = v0-v2, u = q(v1)-p(v3) and w = p(v1)+q(v3). It outputs s+w, t+u, t-u and s-w, in that order, as line elements 0..3. Columns are transformed first and rows second.
- R6: Every sum and difference in a 1-D pass saturates to the signed 16-bit range -32768..32767.
- R7: Each final transform value v is rounded as floor((v+4)/8), which rounds down for negative values.
- R8: The rounded value is added to the prediction pixel at full precision, and the sum is then clamped to 0..255.
- R9: When `in_dc_only` is 1, every output pixel is clamp(pred + floor((c0+4)/8)) and coefficients 1..15 have no effect.
- R10: When the output is stalled and both stages hold tiles, `in_ready` is 0 and no tile is lost. While `out_valid` is 0, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A tile is offered |
| in_ready | output | 1 | The block takes the offered tile at this edge |
| in_dc_only | input | 1 | 1: DC shortcut, 0: full transform |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| in_pred | input | 128 | Sixteen unsigned 8-bit prediction pixels, raster order |
| out_valid | output | 1 | A reconstructed tile is presented |
| out_ready | input | 1 | The consumer takes the presented tile |
| out_pix | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |

## Verification
The bench builds the block with its default widths: 16-bit coefficients and 8-bit pixels. At these widths the saturation corners of the butterflies can be driven directly from the ports, using coefficients of +32767 and -32768. The DC shortcut reaches residuals of about +-4096, which drives the clamp hard against both 0 and 255. The bench also compares directed and pseudo-random tiles against an integer model. A stall sequence fills both stages so that backpressure and in-order draining become visible.

// File: rtl/itx4_pkg.sv
package itx4_pkg;

    // Default widths of one coefficient and one pixel
    localparam int COEF_W   = 16;
    localparam int PIX_W    = 8;

    // Tile geometry: the 1-D pass is a fixed four-point butterfly
    localparam int SIDE     = 4;
    localparam int NPIX     = SIDE * SIDE;

    // Fixed-point multiplier constants and the product shift
    localparam int K_ROT1   = 20091;
    localparam int K_ROT2   = 35468;
    localparam int K_SHIFT  = 16;

    // Final rounding shift
    localparam int RND_SH   = 3;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_DC   = 1'b1
    } mode_e;

endpackage

// File: rtl/itx4_pass.sv
// Four-point 1-D inverse butterfly with saturating arithmetic.
module itx4_pass #(
    parameter int CW = itx4_pkg::COEF_W,
    parameter int K1 = itx4_pkg::K_ROT1,
    parameter int K2 = itx4_pkg::K_ROT2,
    parameter int SH = itx4_pkg::K_SHIFT
) (
    input  logic signed [CW-1:0] e0,
    input  logic signed [CW-1:0] e1,
    input  logic signed [CW-1:0] e2,
    input  logic signed [CW-1:0] e3,
    output logic signed [CW-1:0] f0,
    output logic signed [CW-1:0] f1,
    output logic signed [CW-1:0] f2,
    output logic signed [CW-1:0] f3
);
    localparam int EW = CW + 2;
    localparam int MW = CW + 18;
    localparam logic signed [EW-1:0] HI = EW'((1 <<< (CW - 1)) - 1);
    localparam logic signed [EW-1:0] LO = -EW'(1 <<< (CW - 1));

    function automatic logic signed [CW-1:0] clip(input logic signed [EW-1:0] v);
        if (v > HI) begin
            return HI[CW-1:0];
        end else if (v < LO) begin
            return LO[CW-1:0];
        end
        return v[CW-1:0];
    endfunction

    function automatic logic signed [EW-1:0] mul_hi(input logic signed [CW-1:0] x,
                                                    input int k);
        logic signed [MW-1:0] prod;
        prod = MW'(x) * MW'(k);
        return EW'(prod >>> SH);
    endfunction

    logic signed [CW-1:0] p_e1, q_e1, p_e3, q_e3;
    logic signed [CW-1:0] s_q, t_q, u_q, w_q;

    always_comb begin
        p_e1 = clip(EW'(e1) + mul_hi(e1, K1));
        q_e1 = clip(mul_hi(e1, K2));
        p_e3 = clip(EW'(e3) + mul_hi(e3, K1));
        q_e3 = clip(mul_hi(e3, K2));

        s_q  = clip(EW'(e0) + EW'(e2));
        t_q  = clip(EW'(e0) - EW'(e2));
        u_q  = clip(EW'(q_e1) - EW'(p_e3));
        w_q  = clip(EW'(p_e1) + EW'(q_e3));

        f0   = clip(EW'(s_q) + EW'(w_q));
        f1   = clip(EW'(t_q) + EW'(u_q));
        f2   = clip(EW'(t_q) - EW'(u_q));
        f3   = clip(EW'(s_q) - EW'(w_q));
    end

endmodule

// File: rtl/itx4_pixel.sv
// Rounds one transform value, adds the prediction pixel and clamps.
module itx4_pixel #(
    parameter int CW  = itx4_pkg::COEF_W,
    parameter int PW  = itx4_pkg::PIX_W,
    parameter int RSH = itx4_pkg::RND_SH
) (
    input  logic signed [CW-1:0] v,
    input  logic        [PW-1:0] pred,
    output logic        [PW-1:0] pix
);
    localparam int RW   = CW + 2;
    localparam int HALF = 1 << (RSH - 1);
    localparam logic signed [RW-1:0] PMAX = RW'((1 << PW) - 1);

    logic signed [RW-1:0] rnd;
    logic signed [RW-1:0] sum;

    always_comb begin
        rnd = (RW'(v) + RW'(HALF)) >>> RSH;
        sum = rnd + RW'($signed({1'b0, pred}));
        if (sum < 0) begin
            pix = '0;
        end else if (sum > PMAX) begin
            pix = '1;
        end else begin
            pix = sum[PW-1:0];
        end
    end

endmodule

// File: rtl/itx4_recon.sv
// Two-stage 4x4 inverse transform with reconstruction.
module itx4_recon #(
    parameter int COEF_W = itx4_pkg::COEF_W,
    parameter int PIX_W  = itx4_pkg::PIX_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic                                 in_dc_only,
    input  logic [itx4_pkg::NPIX*COEF_W-1:0]     in_coef,
    input  logic [itx4_pkg::NPIX*PIX_W-1:0]      in_pred,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [itx4_pkg::NPIX*PIX_W-1:0]      out_pix
);
    import itx4_pkg::*;

    typedef struct packed {
        logic                           s1_vld;
        logic                           s1_dc;
        logic [NPIX-1:0][COEF_W-1:0]    s1_mid;
        logic [NPIX-1:0][PIX_W-1:0]     s1_pred;
        logic                           s2_vld;
        logic [NPIX-1:0][PIX_W-1:0]     s2_pix;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [COEF_W-1:0] coef_w [NPIX];
    logic signed [COEF_W-1:0] mid_w  [NPIX];
    logic signed [COEF_W-1:0] fin_w  [NPIX];
    logic signed [COEF_W-1:0] vsel_w [NPIX];
    logic        [PIX_W-1:0]  pix_w  [NPIX];
    logic                     advance;

    // Unpack coefficients, select per-pixel value, pack output
    for (genvar k = 0; k < NPIX; k++) begin : g_elem
        assign coef_w[k] = in_coef[k*COEF_W +: COEF_W];
        assign vsel_w[k] = st_q.s1_dc ? st_q.s1_mid[0] : fin_w[k];
        assign out_pix[k*PIX_W +: PIX_W] = st_q.s2_pix[k];

        itx4_pixel #(.CW(COEF_W), .PW(PIX_W), .RSH(RND_SH)) u_px (
            .v    (vsel_w[k]),
            .pred (st_q.s1_pred[k]),
            .pix  (pix_w[k])
        );
    end

    // Column passes: intermediate element (r, c) lands at SIDE*r + c
    for (genvar c = 0; c < SIDE; c++) begin : g_col
        itx4_pass #(.CW(COEF_W)) u_col (
            .e0 (coef_w[c]),
            .e1 (coef_w[SIDE + c]),
            .e2 (coef_w[2*SIDE + c]),
            .e3 (coef_w[3*SIDE + c]),
            .f0 (mid_w[c]),
            .f1 (mid_w[SIDE + c]),
            .f2 (mid_w[2*SIDE + c]),
            .f3 (mid_w[3*SIDE + c])
        );
    end

    // Row passes on the registered intermediate tile
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        itx4_pass #(.CW(COEF_W)) u_row (
            .e0 (st_q.s1_mid[SIDE*r]),
            .e1 (st_q.s1_mid[SIDE*r + 1]),
            .e2 (st_q.s1_mid[SIDE*r + 2]),
            .e3 (st_q.s1_mid[SIDE*r + 3]),
            .f0 (fin_w[SIDE*r]),
            .f1 (fin_w[SIDE*r + 1]),
            .f2 (fin_w[SIDE*r + 2]),
            .f3 (fin_w[SIDE*r + 3])
        );
    end

    assign advance   = !st_q.s2_vld || out_ready;
    assign in_ready  = !st_q.s1_vld || advance;
    assign out_valid = st_q.s2_vld;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.s2_vld = st_q.s1_vld;
            if (st_q.s1_vld) begin
                for (int k = 0; k < NPIX; k++) begin
                    st_d.s2_pix[k] = pix_w[k];
                end
            end
        end
        if (in_ready) begin
            st_d.s1_vld = in_valid;
            if (in_valid) begin
                st_d.s1_dc = (mode_e'(in_dc_only) == MODE_DC);
                for (int k = 0; k < NPIX; k++) begin
                    st_d.s1_mid[k]  = st_d.s1_dc ? coef_w[k] : mid_w[k];
                    st_d.s1_pred[k] = in_pred[k*PIX_W +: PIX_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/itx4_recon_chk.sv
module itx4_recon_chk #(
    parameter int PIX_W = itx4_pkg::PIX_W
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic                              in_ready,
    input logic                              out_valid,
    input logic                              out_ready,
    input logic [itx4_pkg::NPIX*PIX_W-1:0]   out_pix
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));

    // R10
    ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R2
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

endmodule

bind itx4_recon itx4_recon_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/itx4_recon_test.sv
module itx4_recon_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_dc_only = 1'b0;
    logic [255:0] in_coef = '0;
    logic [127:0] in_pred = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_pix;

    int n_chk = 0;
    int n_fail = 0;
    int tc[16];
    int tp[16];

    always #10 clk = ~clk;

    itx4_recon uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dc_only(in_dc_only), .in_coef(in_coef), .in_pred(in_pred),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    // ---------------- reference model ----------------
    function automatic int s16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int pm(input int x);
        return s16(x + ((x * 20091) >>> 16));
    endfunction

    function automatic int qm(input int x);
        return (x * 35468) >>> 16;
    endfunction

    function automatic void bfly(input int v0, input int v1, input int v2, input int v3,
                                 output int o0, output int o1, output int o2, output int o3);
        int s, t, u, w;
        s  = s16(v0 + v2);
        t  = s16(v0 - v2);
        u  = s16(qm(v1) - pm(v3));
        w  = s16(pm(v1) + qm(v3));
        o0 = s16(s + w);
        o1 = s16(t + u);
        o2 = s16(t - u);
        o3 = s16(s - w);
    endfunction

    function automatic logic [127:0] model_pix(input int dcm);
        int mid[16];
        int fin[16];
        int v, s;
        logic [127:0] res;
        if (dcm != 0) begin
            for (int k = 0; k < 16; k++) fin[k] = tc[0];
        end else begin
            for (int c = 0; c < 4; c++)
                bfly(tc[c], tc[4+c], tc[8+c], tc[12+c], mid[c], mid[4+c], mid[8+c], mid[12+c]);
            for (int r = 0; r < 4; r++)
                bfly(mid[4*r], mid[4*r+1], mid[4*r+2], mid[4*r+3],
                     fin[4*r], fin[4*r+1], fin[4*r+2], fin[4*r+3]);
        end
        for (int k = 0; k < 16; k++) begin
            v = (fin[k] + 4) >>> 3;
            s = v + tp[k];
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            res[k*8 +: 8] = 8'(s);
        end
        return res;
    endfunction

    function automatic logic [255:0] pack_coef();
        logic [255:0] v;
        for (int k = 0; k < 16; k++) v[k*16 +: 16] = 16'(tc[k]);
        return v;
    endfunction

    function automatic logic [127:0] pack_pred();
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(tp[k]);
        return v;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic cmp_pix(input logic [127:0] expv, input string req);
        for (int k = 0; k < 16; k++)
            chk(out_pix[k*8 +: 8] == expv[k*8 +: 8], req,
                int'(out_pix[k*8 +: 8]), int'(expv[k*8 +: 8]));
    endtask

    // One tile, no stall: taken at edge 1, visible after edge 2 (R2)
    task automatic xfer(input int dcm, input string req);
        logic [127:0] expv;
        expv = model_pix(dcm);
        @(negedge clk);
        in_valid   = 1'b1;
        in_dc_only = (dcm != 0);
        in_coef    = pack_coef();
        in_pred    = pack_pred();
        out_ready  = 1'b1;
        chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R2 latency", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 latency", int'(out_valid), 1);
        cmp_pix(expv, req);
    endtask

    task automatic fill(input int cval, input int pval);
        for (int k = 0; k < 16; k++) begin
            tc[k] = cval;
            tp[k] = pval;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_zero();
        logic [127:0] hand;
        for (int k = 0; k < 16; k++) begin
            tc[k] = 0;
            tp[k] = 16 * k + 3;
            hand[k*8 +: 8] = 8'(16 * k + 3);
        end
        xfer(0, "R5 zero");
        cmp_pix(hand, "R5 zero hand");
    endtask

    task automatic t_dc_through_transform();
        logic [127:0] hand;
        fill(0, 50);
        tc[0] = 8;
        for (int k = 0; k < 16; k++) hand[k*8 +: 8] = 8'd51;
        xfer(0, "R5 dc via transform");
        cmp_pix(hand, "R5 dc via transform hand");
    endtask

    task automatic t_mult();
        fill(0, 128);
        tc[4] = 1000;
        xfer(0, "R4 column term");
        fill(0, 128);
        tc[1] = -1000;
        tc[3] = 777;
        xfer(0, "R4 row term");
    endtask

    task automatic t_sat();
        fill(32767, 128);
        xfer(0, "R6 all max");
        fill(-32768, 128);
        xfer(0, "R6 all min");
        for (int k = 0; k < 16; k++) begin
            tc[k] = (k % 2 == 0) ? 32767 : -32768;
            tp[k] = 100;
        end
        xfer(0, "R6 alternating");
    endtask

    task automatic t_dc_mode();
        logic [127:0] hand;
        // c0 = -13: floor(-9/8) = -2; other coefficients are junk (R9)
        for (int k = 0; k < 16; k++) begin
            tc[k] = (k == 0) ? -13 : 12345 - 3000 * k;
            tp[k] = 10 + k;
            hand[k*8 +: 8] = 8'(8 + k);
        end
        xfer(1, "R9 dc junk");
        cmp_pix(hand, "R7 negative rounding");
        fill(5, 40);
        tc[0] = 3;
        for (int k = 0; k < 16; k++) hand[k*8 +: 8] = 8'd40;
        xfer(1, "R7 small dc");
        cmp_pix(hand, "R7 small dc hand");
    endtask

    task automatic t_clamp();
        logic [127:0] hand;
        fill(0, 200);
        tc[0] = 32767;
        for (int k = 0; k < 16; k++) hand[k*8 +: 8] = 8'd255;
        xfer(1, "R8 clamp high");
        cmp_pix(hand, "R8 clamp high hand");
        fill(0, 250);
        tc[0] = -32768;
        for (int k = 0; k < 16; k++) hand[k*8 +: 8] = 8'd0;
        xfer(1, "R8 clamp low");
        cmp_pix(hand, "R8 clamp low hand");
        fill(0, 250);
        tc[0] = 4000;
        tc[5] = -2500;
        xfer(0, "R8 clamp mixed");
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < 16; k++) begin
                if (n < 20) tc[k] = int'($urandom_range(0, 800)) - 400;
                else        tc[k] = int'($urandom_range(0, 65535)) - 32768;
                tp[k] = int'($urandom_range(0, 255));
            end
            xfer(n % 5 == 4 ? 1 : 0, "R5 random");
        end
    endtask

    task automatic t_stall();
        logic [255:0] ca, cb, cc;
        logic [127:0] pa, pb, pc, ea, eb, ec;
        for (int k = 0; k < 16; k++) begin tc[k] = 30 * k - 200; tp[k] = 90; end
        ca = pack_coef(); pa = pack_pred(); ea = model_pix(0);
        for (int k = 0; k < 16; k++) begin tc[k] = -45 * k; tp[k] = 200 - k; end
        cb = pack_coef(); pb = pack_pred(); eb = model_pix(0);
        for (int k = 0; k < 16; k++) begin tc[k] = 640; tp[k] = 7 * k; end
        cc = pack_coef(); pc = pack_pred(); ec = model_pix(1);

        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_dc_only = 1'b0; in_coef = ca; in_pred = pa;
        @(negedge clk);
        in_coef = cb; in_pred = pb;
        @(negedge clk);
        in_dc_only = 1'b1; in_coef = cc; in_pred = pc;
        chk(in_ready == 1'b0, "R10 backpressure", int'(in_ready), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R3 hold valid", int'(out_valid), 1);
            cmp_pix(ea, "R3 hold data");
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        cmp_pix(eb, "R2 order second");
        @(negedge clk);
        chk(out_valid == 1'b1, "R10 no loss", int'(out_valid), 1);
        cmp_pix(ec, "R2 order third");
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 drained", int'(out_valid), 0);
    endtask

    // ---------------- sequencing ----------------
    initial begin
        #15;
        t_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_dc_through_transform();
        t_mult();
        t_sat();
        t_dc_mode();
        t_clamp();
        t_random();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule